// File: doc/BRIEF.md
# Locked Bus Cycle Sequencer

This block is the bus-master end of a simple processor-style bus. A core on one side hands it one operation at a time through a valid/ready request port. The block then produces the bus cycles for that operation on the other side: an address strobe, address, write data, read/write and memory/I/O qualifiers, and a lock signal. It waits for a ready input that ends each cycle.

Four operations are supported. The first two are a single read and a single write; either may ask for lock. The third is a locked read-modify-write: the read data goes back to the core, the core returns a modified value on a separate strobe, and that value is then written. The fourth is a locked interrupt acknowledge, which is two reads with nothing in between.

The sequencer has three jobs. It frames each locked operation with the lock signal, it keeps lock off I/O cycles, and it places at least one bus-idle clock after every cycle. Each bus cycle ends on one ready pulse, and any number of wait states may come before that pulse.

Top module: `lockbus_seq`

## Requirements
- R1: After a synchronous active-high reset, `bus_ads`, `bus_lock` and `done` are low and `req_ready` is high.
- R2: A request accepted at a clock edge (`req_valid` and `req_ready` both high) gives `bus_ads` in the next clock. `bus_addr`, `bus_wr` (1 = write) and `bus_mio` (1 = memory) are valid in that clock. Read data appears on `rd_data` with `rd_valid` in the clock where `bus_brdy` is sampled high. `done` pulses for one clock right after the final `bus_brdy`.
- R3: `bus_ads` is high for exactly one clock per bus cycle. The cycle waits with the strobe low for any number of clocks until `bus_brdy`.
- R4: For a locked operation, `bus_lock` rises in the same clock as the strobe of its first bus cycle.
- R5: `bus_lock` stays high through every clock up to and including the `bus_brdy` of the last cycle of the operation, and it is low in the following clock.
- R6: When one locked operation directly follows another, `bus_lock` is low for at least one clock between them.
- R7: A new `bus_ads` comes at least two clocks after the previous `bus_brdy`, which leaves at least one idle clock between any two bus cycles. With a request already waiting, the new strobe comes exactly two clocks after that `bus_brdy`.
- R8: Operation code 2'b10 (read-modify-write) runs a read cycle, then waits for `mod_valid`, then runs a write cycle with `mod_data`. If the strobe arrives in the clock of the read's `bus_brdy`, the write strobe comes two clocks after that `bus_brdy`. If it arrives k clocks later (k ≥ 1), the write strobe comes in the clock after the strobe.
- R9: Operation code 2'b11 (interrupt acknowledge) runs two read cycles. The second strobe comes two clocks after the first `bus_brdy`. `mod_valid` has no effect on this operation.
- R10: An I/O operation (`req_io` = 1) never raises `bus_lock`, whatever the operation code or `req_lock`, and it drives `bus_mio` low.
- R11: A single read (code 2'b00) or single write (code 2'b01) to memory with `req_lock` high is framed by `bus_lock` as in R4 and R5. Without `req_lock`, it runs with `bus_lock` low.
- R12: `req_ready` is low from the clock after acceptance until the operation's `done` clock. A `req_valid` raised in that time starts no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Sequencer can take a request |
| req_op | input | 2 | 00 read, 01 write, 10 read-modify-write, 11 interrupt acknowledge |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_lock | input | 1 | Ask for lock on a single read or write |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data for a single write |
| mod_valid | input | 1 | Modified-data strobe for read-modify-write |
| mod_data | input | DW | Modified write data |
| rd_valid | output | 1 | Read data valid, one pulse per read cycle |
| rd_data | output | DW | Read data |
| done | output | 1 | One-clock operation completion pulse |
| bus_ads | output | 1 | Address strobe |
| bus_brdy | input | 1 | Bus cycle ready |
| bus_lock | output | 1 | Lock framing |
| bus_wr | output | 1 | 1 = write cycle |
| bus_mio | output | 1 | 1 = memory cycle |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data |

## Verification
Two events can land in the same clock. The first is the release of lock at the end of a locked operation, which happens together with its `done` pulse, and the acceptance of the next locked request. The bench provokes this by holding a queued interrupt acknowledge behind a read-modify-write. It then checks that lock is low in exactly that clock and that the next strobe carries lock two clocks after the final ready. The second is the modified-data strobe of a read-modify-write arriving in the same clock as the read's ready. That case is driven on its own, and it is judged by the write strobe coming two clocks after the ready with the supplied data.

// File: rtl/lockbus_pkg.sv
package lockbus_pkg;

  typedef enum logic [1:0] {
    OP_RD   = 2'b00,
    OP_WR   = 2'b01,
    OP_RMW  = 2'b10,
    OP_INTA = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_MOD,
    ST_GAP,
    ST_REST
  } st_e;

  // operation made of two bus cycles
  function automatic logic op_two_cycles(op_e op);
    return (op == OP_RMW) || (op == OP_INTA);
  endfunction

  // lock is used only on memory space; paired operations always want it
  function automatic logic lock_applies(op_e op, logic lock_req, logic io);
    return (op_two_cycles(op) || lock_req) && !io;
  endfunction

  // direction of the current cycle within the operation
  function automatic logic cycle_writes(op_e op, logic second);
    return (op == OP_WR) || ((op == OP_RMW) && second);
  endfunction

  // is the current cycle the final one of the operation
  function automatic logic cycle_final(op_e op, logic second);
    return second || !op_two_cycles(op);
  endfunction

  // a cycle can be in lock framing in these states
  function automatic logic st_in_frame(st_e st);
    return (st == ST_ADDR) || (st == ST_DATA) || (st == ST_MOD) || (st == ST_GAP);
  endfunction

endpackage

// File: rtl/lockbus_dpath.sv
module lockbus_dpath
  import lockbus_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  op_e           req_op,
  input  logic          req_io,
  input  logic          req_lock,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          mod_take,
  input  logic [DW-1:0] mod_data,
  output op_e           op_q,
  output logic          io_q,
  output logic          lock_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= OP_RD;
      io_q    <= 1'b0;
      lock_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      op_q    <= req_op;
      io_q    <= req_io;
      lock_q  <= lock_applies(req_op, req_lock, req_io);
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end else if (mod_take) begin
      wdata_q <= mod_data;
    end
  end

  // R10
  io_nolock_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && req_io) |=> !lock_q);

endmodule

// File: rtl/lockbus_fsm.sv
module lockbus_fsm
  import lockbus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  op_e  op_q,
  input  logic bus_brdy,
  input  logic mod_valid,
  output st_e  st_q,
  output logic accept,
  output logic req_ready,
  output logic bus_ads,
  output logic cur_write,
  output logic cyc_end,
  output logic last_end,
  output logic mod_take,
  output logic rd_valid,
  output logic done
);

  st_e  st_d;
  logic second_q;
  logic mid_end;
  logic rmw_early;

  assign req_ready = (st_q == ST_IDLE) || (st_q == ST_REST);
  assign accept    = req_valid && req_ready;
  assign bus_ads   = (st_q == ST_ADDR);
  assign cur_write = cycle_writes(op_q, second_q);
  assign cyc_end   = (st_q == ST_DATA) && bus_brdy;
  assign last_end  = cyc_end && cycle_final(op_q, second_q);
  assign mid_end   = cyc_end && !cycle_final(op_q, second_q);
  assign rmw_early = mid_end && (op_q == OP_RMW) && mod_valid;
  assign mod_take  = rmw_early || ((st_q == ST_MOD) && mod_valid);
  assign rd_valid  = cyc_end && !cur_write;
  assign done      = (st_q == ST_REST);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE, ST_REST: st_d = accept ? ST_ADDR : ST_IDLE;
      ST_ADDR:          st_d = ST_DATA;
      ST_DATA: begin
        if (last_end)
          st_d = ST_REST;
        else if (mid_end && (op_q == OP_RMW))
          st_d = mod_valid ? ST_GAP : ST_MOD;
        else if (mid_end)
          st_d = ST_GAP;
        else
          st_d = ST_DATA;
      end
      ST_MOD:           st_d = mod_valid ? ST_ADDR : ST_MOD;
      ST_GAP:           st_d = ST_ADDR;
      default:          st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      second_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept)
        second_q <= 1'b0;
      else if (mid_end)
        second_q <= 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bus_ads && req_ready && !done));

  // R3
  ads_single_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ads |=> !bus_ads);

  // R7
  idle_gap_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_end |=> !bus_ads);

  // R8
  rmw_write_after_mod_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_ads && cur_write && (op_q == OP_RMW)) |-> ($past(mod_take) || $past(st_q == ST_GAP)));

  // R12
  busy_noready_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/lockbus_lockgen.sv
module lockbus_lockgen
  import lockbus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  st_e  st_q,
  input  logic lock_q,
  input  logic last_end,
  input  logic bus_ads,
  input  logic bus_mio,
  output logic bus_lock
);

  assign bus_lock = lock_q && st_in_frame(st_q);

  // R4
  lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_lock) |-> bus_ads);

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_lock && !last_end) |=> bus_lock);

  // R5
  lock_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_lock) |-> $past(last_end));

  // R6
  lock_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_lock && last_end) |=> !bus_lock);

  // R10
  lock_mem_chk: assert property (@(posedge clk) disable iff (rst)
    bus_lock |-> bus_mio);

endmodule

// File: rtl/lockbus_seq.sv
module lockbus_seq
  import lockbus_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic          req_io,
  input  logic          req_lock,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          mod_valid,
  input  logic [DW-1:0] mod_data,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          bus_ads,
  input  logic          bus_brdy,
  output logic          bus_lock,
  output logic          bus_wr,
  output logic          bus_mio,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);

  op_e  op_q;
  st_e  st_q;
  logic io_q;
  logic lock_q;
  logic accept;
  logic cur_write;
  logic cyc_end;
  logic last_end;
  logic mod_take;

  lockbus_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .req_op    (op_e'(req_op)),
    .req_io    (req_io),
    .req_lock  (req_lock),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mod_take  (mod_take),
    .mod_data  (mod_data),
    .op_q      (op_q),
    .io_q      (io_q),
    .lock_q    (lock_q),
    .addr_q    (bus_addr),
    .wdata_q   (bus_wdata)
  );

  lockbus_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .op_q      (op_q),
    .bus_brdy  (bus_brdy),
    .mod_valid (mod_valid),
    .st_q      (st_q),
    .accept    (accept),
    .req_ready (req_ready),
    .bus_ads   (bus_ads),
    .cur_write (cur_write),
    .cyc_end   (cyc_end),
    .last_end  (last_end),
    .mod_take  (mod_take),
    .rd_valid  (rd_valid),
    .done      (done)
  );

  lockbus_lockgen u_lockgen (
    .clk      (clk),
    .rst      (rst),
    .st_q     (st_q),
    .lock_q   (lock_q),
    .last_end (last_end),
    .bus_ads  (bus_ads),
    .bus_mio  (bus_mio),
    .bus_lock (bus_lock)
  );

  assign bus_wr  = cur_write;
  assign bus_mio = !io_q;
  assign rd_data = bus_rdata;

  // R2
  ready_ends_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && !last_end) |=> !done);

endmodule

// File: tb/lockbus_seq_tb.sv
`timescale 1ns/1ps
module lockbus_seq_tb;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [31:0] KEY = 32'h5A5A_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_io = 1'b0, req_lock = 1'b0, mod_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, mod_data = '0;
  logic req_ready, rd_valid, done, bus_ads, bus_lock, bus_wr, bus_mio;
  logic [DW-1:0] rd_data, bus_wdata, bus_rdata;
  logic [AW-1:0] bus_addr;
  logic bus_brdy;

  always #2 clk = ~clk;

  lockbus_seq #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_io(req_io), .req_lock(req_lock), .req_addr(req_addr),
    .req_wdata(req_wdata), .mod_valid(mod_valid), .mod_data(mod_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .bus_ads(bus_ads),
    .bus_brdy(bus_brdy), .bus_lock(bus_lock), .bus_wr(bus_wr), .bus_mio(bus_mio),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bus responder
  int wait_n = 0;
  int cnt = 0;
  logic [AW-1:0] lat_addr = '0;
  logic [DW-1:0] rseq = '0;
  always @(posedge clk) begin
    if (rst) begin
      bus_brdy <= 1'b0; cnt <= 0; rseq <= '0;
    end else if (bus_brdy) begin
      bus_brdy <= 1'b0;
      if (!bus_wr) rseq <= rseq + 1;
    end else if (bus_ads) begin
      cnt <= wait_n; bus_brdy <= (wait_n == 0); lat_addr <= bus_addr;
    end else if (cnt != 0) begin
      cnt <= cnt - 1; bus_brdy <= (cnt == 1);
    end
  end
  assign bus_rdata = lat_addr ^ KEY ^ rseq;

  // monitor
  bit lock_at [4096];
  bit lock_seen;
  int n_ads, n_brdy, n_rdv, n_done, done_t;
  int ads_t [8];
  int brdy_t [8];
  logic [31:0] ads_addr [8];
  logic [31:0] ads_wd [8];
  bit ads_wr [8];
  bit ads_mio [8];
  logic [31:0] rdv_d [8];
  logic [31:0] rdv_seq [8];

  always @(negedge clk) begin
    if (!rst) begin
      lock_at[cyc & 4095] = bus_lock;
      if (bus_lock) lock_seen = 1'b1;
      if (bus_ads && n_ads < 8) begin
        ads_t[n_ads] = cyc; ads_addr[n_ads] = bus_addr; ads_wd[n_ads] = bus_wdata;
        ads_wr[n_ads] = bus_wr; ads_mio[n_ads] = bus_mio; n_ads++;
      end
      if (bus_brdy && n_brdy < 8) begin brdy_t[n_brdy] = cyc; n_brdy++; end
      if (rd_valid && n_rdv < 8) begin rdv_d[n_rdv] = rd_data; rdv_seq[n_rdv] = rseq; n_rdv++; end
      if (done) begin done_t = cyc; n_done++; end
    end
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    n_ads = 0; n_brdy = 0; n_rdv = 0; n_done = 0; lock_seen = 1'b0;
  endtask

  task automatic issue(input logic [1:0] op, input bit io, input bit lk,
                       input logic [31:0] a, input logic [31:0] wd, output int acc);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_io = io; req_lock = lk;
    req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    acc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic mod_feed(input int d, input logic [31:0] md, output int tb_, output int tm);
    while (!rd_valid) @(negedge clk);
    tb_ = cyc;
    repeat (d) @(negedge clk);
    mod_valid = 1'b1; mod_data = md; tm = cyc;
    @(negedge clk);
    mod_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic bit span_locked(input int a, input int b);
    for (int i = a; i <= b; i++) if (!lock_at[i & 4095]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    // R1
    chk(!bus_ads && !bus_lock && !done && req_ready, "R1", "reset outputs",
        {bus_ads, bus_lock, done, req_ready}, 4'b0001);
  endtask

  task automatic t_single_read();
    int acc;
    wait_n = 0; clear_log();
    issue(2'b00, 0, 0, 32'h0000_1240, 0, acc);
    wait_done();
    // R2
    chk(ads_t[0] == acc + 1, "R2", "ads clock", ads_t[0], acc + 1);
    chk(ads_addr[0] == 32'h0000_1240 && !ads_wr[0] && ads_mio[0], "R2", "ads qualifiers",
        {ads_addr[0], ads_wr[0], ads_mio[0]}, {32'h0000_1240, 1'b0, 1'b1});
    chk(rdv_d[0] == (32'h0000_1240 ^ KEY ^ rdv_seq[0]), "R2", "read data",
        rdv_d[0], 32'h0000_1240 ^ KEY ^ rdv_seq[0]);
    chk(done_t == brdy_t[0] + 1 && n_done == 1, "R2", "done clock", done_t, brdy_t[0] + 1);
    // R11 unlocked single cycle
    chk(!lock_seen, "R11", "no lock without request", lock_seen, 0);
  endtask

  task automatic t_single_write_waits();
    int acc;
    wait_n = 3; clear_log();
    issue(2'b01, 0, 0, 32'h0000_2000, 32'hCAFE_0001, acc);
    wait_done();
    // R3
    chk(n_ads == 1, "R3", "one strobe", n_ads, 1);
    chk(brdy_t[0] == ads_t[0] + 4, "R3", "wait states", brdy_t[0], ads_t[0] + 4);
    chk(ads_wr[0] && ads_wd[0] == 32'hCAFE_0001, "R3", "write data", ads_wd[0], 32'hCAFE_0001);
    chk(n_rdv == 0, "R3", "no read pulse on write", n_rdv, 0);
  endtask

  task automatic t_rmw(input int w, input int d);
    int acc, tb_, tm, exp_a1;
    wait_n = w; clear_log();
    issue(2'b10, 0, 0, 32'h0000_3300, 0, acc);
    mod_feed(d, 32'h0BAD_F00D + d, tb_, tm);
    wait_done();
    exp_a1 = (d == 0) ? tb_ + 2 : tm + 1;
    // R8
    chk(n_ads == 2 && !ads_wr[0] && ads_wr[1], "R8", "read then write",
        {ads_wr[0], ads_wr[1]}, 2'b01);
    chk(ads_t[1] == exp_a1, "R8", "write strobe clock", ads_t[1], exp_a1);
    chk(ads_wd[1] == 32'h0BAD_F00D + d, "R8", "modified data", ads_wd[1], 32'h0BAD_F00D + d);
    chk(rdv_d[0] == (32'h0000_3300 ^ KEY ^ rdv_seq[0]), "R8", "rmw read data",
        rdv_d[0], 32'h0000_3300 ^ KEY ^ rdv_seq[0]);
    // R4
    chk(lock_at[ads_t[0] & 4095] && !lock_at[(ads_t[0] - 1) & 4095], "R4", "lock rise at strobe",
        lock_at[ads_t[0] & 4095], 1);
    // R5
    chk(span_locked(ads_t[0], brdy_t[1]), "R5", "lock held over operation", 0, 1);
    chk(!lock_at[(brdy_t[1] + 1) & 4095], "R5", "lock released", 1, 0);
    // R7
    chk(ads_t[1] >= brdy_t[0] + 2, "R7", "idle clock inside rmw", ads_t[1], brdy_t[0] + 2);
  endtask

  task automatic t_inta();
    int acc;
    wait_n = 2; clear_log();
    issue(2'b11, 0, 0, 32'h0000_0040, 0, acc);
    mod_valid = 1'b1; mod_data = 32'hDEAD_DEAD;
    @(negedge clk);
    mod_valid = 1'b0;
    wait_done();
    // R9
    chk(n_ads == 2 && !ads_wr[0] && !ads_wr[1], "R9", "two reads, mod ignored",
        {n_ads, ads_wr[0], ads_wr[1]}, {32'd2, 2'b00});
    chk(ads_t[1] == brdy_t[0] + 2, "R9", "second strobe", ads_t[1], brdy_t[0] + 2);
    chk(n_rdv == 2 && rdv_d[1] == (32'h0000_0040 ^ KEY ^ (rdv_seq[0] + 1)), "R9", "second read data",
        rdv_d[1], 32'h0000_0040 ^ KEY ^ (rdv_seq[0] + 1));
    chk(span_locked(ads_t[0], brdy_t[1]) && !lock_at[(brdy_t[1] + 1) & 4095], "R9",
        "lock frames both reads", 0, 1);
  endtask

  task automatic t_back_to_back();
    int acc, acc2, tb_, tm;
    wait_n = 0; clear_log();
    issue(2'b10, 0, 0, 32'h0000_5000, 0, acc);
    mod_feed(1, 32'h1111_2222, tb_, tm);
    issue(2'b11, 0, 0, 32'h0000_0044, 0, acc2);
    wait_done();
    // R6
    chk(n_ads == 4 && !lock_at[(brdy_t[1] + 1) & 4095], "R6", "lock drop between ops",
        lock_at[(brdy_t[1] + 1) & 4095], 0);
    // R7
    chk(ads_t[2] == brdy_t[1] + 2, "R7", "queued strobe clock", ads_t[2], brdy_t[1] + 2);
    // R4
    chk(lock_at[ads_t[2] & 4095], "R4", "lock with queued strobe", 0, 1);
  endtask

  task automatic t_io();
    int acc;
    wait_n = 1; clear_log();
    issue(2'b11, 1, 1, 32'h0000_0020, 0, acc);
    wait_done();
    issue(2'b01, 1, 1, 32'h0000_0060, 32'h77, acc);
    wait_done();
    // R10
    chk(!lock_seen, "R10", "no lock on io", lock_seen, 0);
    chk(n_ads == 3 && !ads_mio[0] && !ads_mio[1] && !ads_mio[2], "R10", "io qualifier",
        {ads_mio[0], ads_mio[1], ads_mio[2]}, 3'b000);
  endtask

  task automatic t_locked_single();
    int acc;
    wait_n = 2; clear_log();
    issue(2'b00, 0, 1, 32'h0000_7000, 0, acc);
    wait_done();
    // R11
    chk(lock_at[ads_t[0] & 4095] && !lock_at[(ads_t[0] - 1) & 4095], "R11", "lock rise", 0, 1);
    chk(span_locked(ads_t[0], brdy_t[0]) && !lock_at[(brdy_t[0] + 1) & 4095], "R11",
        "lock span single", 0, 1);
  endtask

  task automatic t_busy();
    int acc;
    bit rdy_seen;
    wait_n = 5; clear_log(); rdy_seen = 1'b0;
    issue(2'b00, 0, 0, 32'h0000_8800, 0, acc);
    req_valid = 1'b1; req_op = 2'b01; req_addr = 32'h0000_9999;
    repeat (3) begin
      if (req_ready) rdy_seen = 1'b1;
      @(negedge clk);
    end
    req_valid = 1'b0;
    wait_done();
    repeat (3) @(negedge clk);
    // R12
    chk(!rdy_seen, "R12", "ready low while busy", rdy_seen, 0);
    chk(n_ads == 1 && !ads_wr[0] && ads_addr[0] == 32'h0000_8800, "R12", "no extra cycle",
        n_ads, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single_read();
    t_single_write_waits();
    t_rmw(1, 3);
    t_rmw(0, 0);
    t_inta();
    t_back_to_back();
    t_io();
    t_locked_single();
    t_busy();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule